// File: doc/BRIEF.md
# Multi-link event broadcast sequencer

This block gathers event data from up to eight byte-wide link buffers and broadcasts every event onto a 128-bit write bus, one link after another. Each buffer entry carries a byte plus a boundary flag; a flagged entry closes the current event, so events can be any length. A control side sets which links take part, the high address bits and broadcast mode, arms the transfer with a go pulse, flushes all buffers with a drain pulse, and can inject test entries into any buffer. A live 5-bit count of complete events per link is driven on output pins.

Once armed, the block waits until every selected link holds a whole event. It then requests the bus and writes the first selected link's data, 16 bytes per word. After that link it drops its request so other masters can take the bus, and repeats for the next selected link. When the last link is sent it pulses end-of-event, discards the event from every selected buffer and steps the rolling event number.

Top module: `evt_bcast_seq`

## Requirements
- R1: A buffer entry is 9 bits; bit 8 set marks the end of an event and its low byte is discarded. Each link buffer holds 32 entries; a write to a full buffer, or a flagged write when the link already holds 31 events, is dropped. A test write to a link in the same cycle as a receiver write to that link takes precedence.
- R2: `evt_cnt[5*i+4:5*i]` always shows the number of complete events held for link i (0 to 31).
- R3: A transfer starts only after a go pulse, and only when `link_mask` is non-zero and every selected link holds at least one complete event; one go pulse sends one event, and a go arriving during a transfer arms the following one.
- R4: Selected links are sent in ascending link number, latched at the start of the event; `bus_addr[7:4]` carries the link number.
- R5: `bus_addr[3:0]` carries the event number, equal for all links of an event and advancing by one modulo 16 after each event; `bus_addr[31:8]` equals `addr_hi`, or zero when `bcast` is 1.
- R6: Bytes are packed little-endian (first byte in bits [7:0]) and the final word of a link is zero-filled; an event of N bytes takes ceil(N/16) words, and an empty event sends one all-zero word.
- R7: `bus_req` stays high through a link's words and is low for exactly the one cycle after each link's last write.
- R8: `bus_wr` is asserted only while `bus_gnt` is high; a grant that drops in the middle of a link pauses the transfer without losing or repeating data.
- R9: `bus_eoe` is a one-cycle pulse in the cycle after the last write of the last selected link; then each selected link's count drops by one and unselected links are unaffected.
- R10: A drain pulse empties every buffer, zeroes the counts, ends any transfer, clears a pending go and resets the event number to 0.
- R11: After reset all counts are zero, no request, write or end-of-event is asserted, and the event number is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_wr | input | 8 | Per-link receiver write strobe |
| rx_data | input | 72 | Per-link 9-bit receiver entry, link i at [9i+8:9i] |
| tw_en | input | 1 | Test write strobe |
| tw_link | input | 4 | Link targeted by the test write |
| tw_data | input | 9 | Test entry |
| link_mask | input | 8 | Links taking part in the event |
| addr_hi | input | 24 | Upper address bits |
| bcast | input | 1 | Broadcast mode: upper address forced to zero |
| go | input | 1 | Arm one event transfer |
| drain | input | 1 | Flush all buffers and reinitialize |
| evt_cnt | output | 40 | Per-link complete-event counts, 5 bits each |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_wr | output | 1 | Write valid this cycle |
| bus_addr | output | 32 | Write address |
| bus_data | output | 128 | Write data |
| bus_eoe | output | 1 | End-of-event pulse |

## Verification
The hardest situation to reach is a grant that vanishes part-way through a multi-word link while other links of lengths straddling the 16-byte boundary wait behind it. The bench sweeps twenty events with rotating link masks, lengths taken from 0, 1, 2, 15, 16, 17, 30 and 31 bytes, and three grant patterns (steady, every other cycle, one in three), predicting every address and data word from the length and a byte formula. Directed runs cover gating on an incomplete link, an empty mask, drain clearing a pending go, test-write precedence and both overflow limits.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
    localparam int ENT_W      = 9;
    localparam int WORD_BYTES = 16;
    localparam int ID_W       = 4;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SEND,
        SQ_GAP
    } sq_state_e;
endpackage

// File: rtl/ebs_link_fifo.sv
module ebs_link_fifo
    import ebs_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int EVW   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      drain,
    input  logic                      wr_en,
    input  logic [ENT_W-1:0]          wr_data,
    input  logic                      pop,
    input  logic                      rel,
    output logic [8*WORD_BYTES-1:0]   word,
    output logic                      word_last,
    output logic [EVW-1:0]            evt_cnt
);
    localparam int PW     = $clog2(DEPTH);
    localparam int OCW    = PW + 1;
    localparam int LANES  = WORD_BYTES;
    localparam int ADVW   = $clog2(LANES + 2);
    localparam int EV_MAX = (1 << EVW) - 1;

    typedef struct packed {
        logic [PW-1:0]  wr;
        logic [PW-1:0]  rd;
        logic [OCW-1:0] occ;
        logic [EVW-1:0] ev;
    } lf_t;

    lf_t q, d;
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic             accept;
    logic             hit;
    logic [ADVW-1:0]  mark_pos;
    logic [ADVW-1:0]  adv;

    // Window of LANES+1 entries from the head: find the first boundary flag.
    always_comb begin
        hit      = 1'b0;
        mark_pos = ADVW'(LANES + 1);
        word     = '0;
        for (int k = 0; k <= LANES; k++) begin
            if (!hit && mem_q[PW'(q.rd + PW'(k))][ENT_W-1]) begin
                hit      = 1'b1;
                mark_pos = ADVW'(k);
            end
        end
        for (int k = 0; k < LANES; k++) begin
            if (ADVW'(k) < mark_pos) begin
                word[8*k +: 8] = mem_q[PW'(q.rd + PW'(k))][7:0];
            end
        end
        word_last = hit;
        adv       = hit ? ADVW'(mark_pos + 1'b1) : ADVW'(LANES);
    end

    always_comb begin
        d      = q;
        accept = wr_en && !drain && (q.occ < OCW'(DEPTH))
                 && !(wr_data[ENT_W-1] && (q.ev == EVW'(EV_MAX)));
        if (drain) begin
            d = '0;
        end else begin
            if (accept) begin
                d.wr = q.wr + 1'b1;
            end
            if (pop) begin
                d.rd = q.rd + PW'(adv);
            end
            d.occ = q.occ + OCW'(accept) - (pop ? OCW'(adv) : OCW'(0));
            d.ev  = q.ev + EVW'(accept && wr_data[ENT_W-1]) - EVW'(rel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem_q[q.wr] <= wr_data;
        end
    end

    assign evt_cnt = q.ev;

    // R2: at most one event (the one in flight) can be counted beyond the stored entries
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q.ev) <= int'(q.occ) + 1));
    // R9: an event is only released when one is held
    a_r9_rel_has_event: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> (q.ev != '0));
    // R1: a full buffer stays full while nothing is read
    a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.occ == OCW'(DEPTH) && wr_en && !pop && !drain) |=> (q.occ == OCW'(DEPTH)));
    // R10: drain leaves the buffer empty
    a_r10_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
        drain |=> (q.occ == '0 && q.ev == '0));
endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
    import ebs_pkg::*;
#(
    parameter int NLINK = 8,
    parameter int EVW   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic                  drain,
    input  logic [NLINK-1:0]      link_mask,
    input  logic [NLINK*EVW-1:0]  evt_cnt_all,
    input  logic                  word_last,
    input  logic                  bus_gnt,
    output logic                  bus_req,
    output logic                  bus_wr,
    output logic                  bus_eoe,
    output logic [ID_W-1:0]       cur_link,
    output logic [ID_W-1:0]       evt_id,
    output logic [NLINK-1:0]      pop_vec,
    output logic [NLINK-1:0]      rel_vec
);
    typedef struct packed {
        sq_state_e        st;
        logic             armed;
        logic [NLINK-1:0] mask;
        logic [ID_W-1:0]  cur;
        logic [ID_W-1:0]  evt;
    } sq_t;

    sq_t q, d;
    logic            ready;
    logic [ID_W-1:0] first;
    logic            nxt_ok;
    logic [ID_W-1:0] nxt;

    always_comb begin
        ready = |link_mask;
        first = '0;
        for (int i = NLINK - 1; i >= 0; i--) begin
            if (link_mask[i]) begin
                first = ID_W'(i);
                if (evt_cnt_all[i*EVW +: EVW] == '0) begin
                    ready = 1'b0;
                end
            end
        end
        nxt_ok = 1'b0;
        nxt    = '0;
        for (int i = NLINK - 1; i >= 0; i--) begin
            if (q.mask[i] && (ID_W'(i) > q.cur)) begin
                nxt_ok = 1'b1;
                nxt    = ID_W'(i);
            end
        end
    end

    always_comb begin
        d       = q;
        d.armed = q.armed | go;
        bus_req = 1'b0;
        bus_wr  = 1'b0;
        bus_eoe = 1'b0;
        pop_vec = '0;
        rel_vec = '0;
        case (q.st)
            SQ_IDLE: begin
                if (q.armed && ready) begin
                    d.st    = SQ_SEND;
                    d.mask  = link_mask;
                    d.cur   = first;
                    d.armed = go;
                end
            end
            SQ_SEND: begin
                bus_req = 1'b1;
                bus_wr  = bus_gnt;
                pop_vec = NLINK'(bus_gnt) << q.cur;
                if (bus_gnt && word_last) begin
                    d.st = SQ_GAP;
                end
            end
            SQ_GAP: begin
                if (nxt_ok) begin
                    d.cur = nxt;
                    d.st  = SQ_SEND;
                end else begin
                    bus_eoe = 1'b1;
                    rel_vec = q.mask;
                    d.evt   = q.evt + 1'b1;
                    d.st    = SQ_IDLE;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
        if (drain) begin
            d.st    = SQ_IDLE;
            d.armed = 1'b0;
            d.evt   = '0;
            bus_req = 1'b0;
            bus_wr  = 1'b0;
            bus_eoe = 1'b0;
            pop_vec = '0;
            rel_vec = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, armed: 1'b0, mask: '0, cur: '0, evt: '0};
        end else begin
            q <= d;
        end
    end

    assign cur_link = q.cur;
    assign evt_id   = q.evt;

    // R8: no write without the grant
    a_r8_wr_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_gnt && bus_req));
    // R7: request drops after the last word of a link
    a_r7_gap_after_link: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && word_last) |=> !bus_req);
    // R9: end-of-event lasts one cycle
    a_r9_eoe_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_eoe |=> !bus_eoe);
    // R5: event number steps by one after each event
    a_r5_evt_step: assert property (@(posedge clk) disable iff (!rst_n)
        bus_eoe |=> (evt_id == $past(evt_id) + 4'd1));
    // R4: the next link of an event is always higher-numbered
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_GAP && !drain) |=> (q.st == SQ_IDLE || q.cur > $past(q.cur)));
endmodule

// File: rtl/evt_bcast_seq.sv
module evt_bcast_seq
    import ebs_pkg::*;
#(
    parameter int NLINK  = 8,
    parameter int DEPTH  = 32,
    parameter int EVW    = 5,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NLINK-1:0]          rx_wr,
    input  logic [NLINK*ENT_W-1:0]    rx_data,
    input  logic                      tw_en,
    input  logic [ID_W-1:0]           tw_link,
    input  logic [ENT_W-1:0]          tw_data,
    input  logic [NLINK-1:0]          link_mask,
    input  logic [ADDR_W-2*ID_W-1:0]  addr_hi,
    input  logic                      bcast,
    input  logic                      go,
    input  logic                      drain,
    output logic [NLINK*EVW-1:0]      evt_cnt,
    output logic                      bus_req,
    input  logic                      bus_gnt,
    output logic                      bus_wr,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [8*WORD_BYTES-1:0]   bus_data,
    output logic                      bus_eoe
);
    localparam int UP_W = ADDR_W - 2 * ID_W;
    localparam int LSEL = (NLINK > 1) ? $clog2(NLINK) : 1;

    logic [8*WORD_BYTES-1:0] word_a [NLINK];
    logic [NLINK-1:0]        last_a;
    logic [NLINK-1:0]        pop_vec;
    logic [NLINK-1:0]        rel_vec;
    logic [ID_W-1:0]         cur_link;
    logic [ID_W-1:0]         evt_id;
    logic [8*WORD_BYTES-1:0] sel_word;
    logic                    sel_last;

    for (genvar i = 0; i < NLINK; i++) begin : g_link
        logic             tsel;
        logic             wen;
        logic [ENT_W-1:0] wdat;

        assign tsel = tw_en && (tw_link == ID_W'(i));
        assign wen  = rx_wr[i] | tsel;
        assign wdat = tsel ? tw_data : rx_data[i*ENT_W +: ENT_W];

        ebs_link_fifo #(
            .DEPTH (DEPTH),
            .EVW   (EVW)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .drain     (drain),
            .wr_en     (wen),
            .wr_data   (wdat),
            .pop       (pop_vec[i]),
            .rel       (rel_vec[i]),
            .word      (word_a[i]),
            .word_last (last_a[i]),
            .evt_cnt   (evt_cnt[i*EVW +: EVW])
        );
    end

    ebs_seq #(
        .NLINK (NLINK),
        .EVW   (EVW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .drain       (drain),
        .link_mask   (link_mask),
        .evt_cnt_all (evt_cnt),
        .word_last   (sel_last),
        .bus_gnt     (bus_gnt),
        .bus_req     (bus_req),
        .bus_wr      (bus_wr),
        .bus_eoe     (bus_eoe),
        .cur_link    (cur_link),
        .evt_id      (evt_id),
        .pop_vec     (pop_vec),
        .rel_vec     (rel_vec)
    );

    assign sel_word = word_a[cur_link[LSEL-1:0]];
    assign sel_last = last_a[cur_link[LSEL-1:0]];
    assign bus_addr = {(bcast ? UP_W'(0) : addr_hi), cur_link, evt_id};
    assign bus_data = bus_wr ? sel_word : '0;
endmodule

// File: tb/evt_bcast_seq_bench.sv
module evt_bcast_seq_bench;
    localparam int NL = 8;
    localparam int EW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NL-1:0]  rx_wr = '0;
    logic [NL*9-1:0] rx_data = '0;
    logic           tw_en = 1'b0;
    logic [3:0]     tw_link = '0;
    logic [8:0]     tw_data = '0;
    logic [NL-1:0]  link_mask = '0;
    logic [23:0]    addr_hi = '0;
    logic           bcast = 1'b0;
    logic           go = 1'b0;
    logic           drain = 1'b0;
    logic [NL*EW-1:0] evt_cnt;
    logic           bus_req;
    logic           bus_gnt = 1'b0;
    logic           bus_wr;
    logic [31:0]    bus_addr;
    logic [127:0]   bus_data;
    logic           bus_eoe;

    evt_bcast_seq u_evt_bcast_seq (
        .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_data(rx_data),
        .tw_en(tw_en), .tw_link(tw_link), .tw_data(tw_data),
        .link_mask(link_mask), .addr_hi(addr_hi), .bcast(bcast),
        .go(go), .drain(drain), .evt_cnt(evt_cnt), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_eoe(bus_eoe)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int gmode = 0;

    // reference model state
    int exp_len [NL];
    int exp_seed = 0;
    logic [NL-1:0] run_mask = '0;
    int exp_link = 0;
    int exp_word = 0;
    int exp_evt = 0;
    bit mon_on = 0;
    bit gap_pend = 0;
    bit eoe_exp = 0;
    bit eoe_seen = 0;

    function automatic logic [7:0] pat(input int l, input int k, input int s);
        return 8'(s * 5 + k * 7 + l * 3 + 1);
    endfunction

    function automatic int len_opt(input int i);
        case (i % 8)
            0: return 0;  1: return 1;  2: return 2;  3: return 15;
            4: return 16; 5: return 17; 6: return 30; default: return 31;
        endcase
    endfunction

    function automatic logic [NL-1:0] mask_opt(input int r);
        case (r)
            0: return 8'hFF; 1: return 8'h01; 2: return 8'h80; 3: return 8'hA5;
            4: return 8'h5A; 5: return 8'h03; 6: return 8'hC0; 7: return 8'h11;
            8: return 8'hFE; 9: return 8'h7F;
            default: return (8'(r * 29 + 13) == 8'h00) ? 8'h01 : 8'(r * 29 + 13);
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int cnt_of(input int l);
        return int'(evt_cnt[l*EW +: EW]);
    endfunction

    // grant driver, settles after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            case (gmode)
                0: bus_gnt = bus_req;
                1: bus_gnt = bus_req && (cyc % 2 == 0);
                default: bus_gnt = bus_req && (cyc % 3 == 0);
            endcase
        end
    end

    // bus monitor, samples at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (gap_pend) begin
                chk(!bus_req, "R7 request low in gap", 128'(bus_req), 128'(0));
                chk(bus_eoe == eoe_exp, "R9 end-of-event timing", 128'(bus_eoe), 128'(eoe_exp));
                if (eoe_exp) begin
                    eoe_seen = 1;
                    mon_on   = 0;
                    exp_evt  = (exp_evt + 1) % 16;
                end
                gap_pend = 0;
            end else if (bus_eoe) begin
                chk(0, "R9 stray end-of-event", 128'(1), 128'(0));
            end
            if (bus_req && !bus_gnt) begin
                chk(!bus_wr, "R8 write without grant", 128'(bus_wr), 128'(0));
            end
            if (bus_wr) begin
                if (!mon_on) begin
                    chk(0, "R3 unexpected write", 128'(bus_addr), 128'(0));
                end else begin
                    logic [127:0] ew;
                    logic [31:0]  ea;
                    int nw;
                    int nx;
                    ew = '0;
                    for (int j = 0; j < 16; j++) begin
                        int b;
                        b = exp_word * 16 + j;
                        if (b < exp_len[exp_link]) ew[8*j +: 8] = pat(exp_link, b, exp_seed);
                    end
                    ea = {(bcast ? 24'h0 : addr_hi), 4'(exp_link), 4'(exp_evt)};
                    chk(bus_addr == ea, "R4 R5 write address", 128'(bus_addr), 128'(ea));
                    chk(bus_data == ew, "R6 R1 write data", bus_data, ew);
                    nw = (exp_len[exp_link] == 0) ? 1 : (exp_len[exp_link] + 15) / 16;
                    if (exp_word >= nw - 1) begin
                        gap_pend = 1;
                        nx = -1;
                        for (int i = NL - 1; i > exp_link; i--) if (run_mask[i]) nx = i;
                        if (nx < 0) eoe_exp = 1;
                        else begin
                            eoe_exp  = 0;
                            exp_link = nx;
                        end
                        exp_word = 0;
                    end else begin
                        exp_word++;
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic put_entry(input int l, input logic [8:0] e);
        rx_wr = '0;
        rx_wr[l] = 1'b1;
        rx_data[l*9 +: 9] = e;
        tick(1);
        rx_wr = '0;
    endtask

    task automatic put_event(input int l, input int len, input int s, input bit ovr);
        exp_len[l] = len;
        for (int k = 0; k < len; k++) begin
            rx_wr = '0;
            rx_wr[l] = 1'b1;
            rx_data[l*9 +: 9] = {1'b0, (ovr && k == 0) ? ~pat(l, k, s) : pat(l, k, s)};
            if (ovr && k == 0) begin
                tw_en   = 1'b1;
                tw_link = 4'(l);
                tw_data = {1'b0, pat(l, k, s)};
            end
            tick(1);
            rx_wr = '0;
            tw_en = 1'b0;
        end
        put_entry(l, 9'h1AA);
    endtask

    task automatic setup_run(input logic [NL-1:0] m, input int s);
        run_mask = m;
        link_mask = m;
        exp_seed = s;
        exp_word = 0;
        eoe_seen = 0;
        exp_link = 0;
        for (int i = NL - 1; i >= 0; i--) if (m[i]) exp_link = i;
        mon_on = 1;
    endtask

    task automatic pulse_go();
        go = 1'b1;
        tick(1);
        go = 1'b0;
    endtask

    task automatic pulse_drain();
        drain = 1'b1;
        tick(1);
        drain = 1'b0;
        exp_evt = 0;
        mon_on = 0;
    endtask

    task automatic wait_done(input string tag);
        for (int t = 0; t < 3000 && !eoe_seen; t++) tick(1);
        chk(eoe_seen, tag, 128'(eoe_seen), 128'(1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        // R11 reset state
        chk(evt_cnt == '0, "R11 counts after reset", 128'(evt_cnt), 128'(0));
        chk(!bus_req && !bus_wr && !bus_eoe, "R11 bus idle after reset",
            128'({bus_req, bus_wr, bus_eoe}), 128'(0));
        rst_n = 1'b1;
        tick(2);

        // R3 gating on an incomplete link, R9 unselected link untouched
        put_event(5, 3, 77, 0);
        setup_run(8'h03, 100);
        put_event(0, 5, 100, 0);
        pulse_go();
        tick(20);
        chk(!bus_req, "R3 wait for every selected link", 128'(bus_req), 128'(0));
        chk(cnt_of(0) == 1, "R2 count link0", 128'(cnt_of(0)), 128'(1));
        put_event(1, 3, 100, 0);
        wait_done("R3 event after last link complete");
        tick(2);
        chk(cnt_of(0) == 0 && cnt_of(1) == 0, "R9 selected links released",
            128'({cnt_of(0), cnt_of(1)}), 128'(0));
        chk(cnt_of(5) == 1, "R9 unselected link kept", 128'(cnt_of(5)), 128'(1));

        // R3 empty mask never starts; R10 drain
        link_mask = '0;
        pulse_go();
        tick(20);
        chk(!bus_req, "R3 empty mask idle", 128'(bus_req), 128'(0));
        pulse_drain();
        tick(1);
        chk(evt_cnt == '0, "R10 counts cleared", 128'(evt_cnt), 128'(0));
        setup_run(8'h01, 200);
        put_event(0, 2, 200, 0);
        tick(20);
        chk(!bus_req, "R10 pending go cleared", 128'(bus_req), 128'(0));
        pulse_go();
        wait_done("R10 event number restarts at 0");

        // R1 test write wins over receiver write
        setup_run(8'h40, 300);
        put_event(6, 4, 300, 1);
        pulse_go();
        wait_done("R1 test-write event sent");

        // R1 full buffer drops the boundary entry
        for (int k = 0; k < 32; k++) put_entry(2, {1'b0, 8'(k)});
        put_entry(2, 9'h100);
        tick(1);
        chk(cnt_of(2) == 0, "R1 write to full buffer dropped", 128'(cnt_of(2)), 128'(0));
        pulse_drain();
        // R1/R2 event limit of 31
        for (int k = 0; k < 31; k++) put_entry(3, 9'h100);
        tick(1);
        chk(cnt_of(3) == 31, "R2 count reaches 31", 128'(cnt_of(3)), 128'(31));
        put_entry(3, 9'h100);
        tick(1);
        chk(cnt_of(3) == 31, "R1 boundary beyond 31 dropped", 128'(cnt_of(3)), 128'(31));
        pulse_drain();
        tick(1);
        chk(cnt_of(3) == 0, "R10 drain after limit", 128'(cnt_of(3)), 128'(0));

        // sweep: masks, lengths at word boundaries, grant patterns
        for (int r = 0; r < 20; r++) begin
            logic [NL-1:0] m;
            m = mask_opt(r);
            addr_hi = 24'(r * 12345 + 7);
            bcast = r[0];
            gmode = r % 3;
            setup_run(m, r + 1);
            mon_on = 0;
            for (int l = 0; l < NL; l++) begin
                if (m[l]) put_event(l, len_opt(r + 3 * l), r + 1, 0);
            end
            tick(1);
            for (int l = 0; l < NL; l++) begin
                chk(cnt_of(l) == int'(m[l]), "R2 per-link count", 128'(cnt_of(l)), 128'(m[l]));
            end
            mon_on = 1;
            pulse_go();
            wait_done("R9 sweep event completes");
            tick(2);
            chk(evt_cnt == '0, "R9 events released", 128'(evt_cnt), 128'(0));
        end
        gmode = 0;
        tick(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule